// File: doc/BRIEF.md
# Pin Interrupt Routing Controller

This block gathers interrupt requests from the pins of several 16-bit GPIO ports and folds them into one 32-bit request vector with a single interrupt output. Each of the four byte lanes of the vector takes one 8-bit half port. Lanes 0 and 2 accept only lower halves (pins 7..0) and lanes 1 and 3 accept only upper halves (pins 15..8). A per-lane code in the steering register chooses the port. Software normally writes the same code into both bytes of one 16-bit half of that register. The whole port then occupies the low or the high half of the vector.

Every vector bit has its own polarity flag, edge/level selection and enable. Flags are changed through paired set and clear addresses that act only on bits written as one. A request fires when the sensed (possibly inverted) bit goes from 0 to 1 in edge mode, or while it is 1 in level mode. A latched request stays until software writes one to it. The interrupt output is a registered OR of all requests whose enable is set.

Top module: `pint_router`

## Requirements
- R1: After the synchronous reset every register reads zero (all bits disabled, non-inverted, level sensitive, no request) and `irq_o` is low.
- R2: Byte lane b of the vector carries pins 8*(b mod 2)+7..8*(b mod 2) of the port whose index equals byte b of the steering register (address 3). Pin i of port p is `pins_i[16*p+i]`. A code of NPORT or above gives zeros on that lane.
- R3: The sensed bit is the routed pin XOR its invert flag. Writing ones to address 6 sets flags and writing ones to address 7 clears them. Both addresses read back the current flags.
- R4: In edge mode a request is latched only on a 0-to-1 change of the sensed bit. A 1-to-0 change latches nothing. Edge flags are set at address 4 and cleared at address 5, and both addresses read the flags.
- R5: In level mode a request is latched in every cycle the sensed bit is 1. If the bit is still 1 after it is cleared, the request is set again one cycle after the clear.
- R6: Writing ones to the request register (address 2) clears those requests. In edge mode a cleared request stays clear until a new rising sensed edge arrives.
- R7: Ones written to address 0 enable bits and ones written to address 1 disable them, and both addresses read the enables. `irq_o` equals the OR of (request AND enable) as it stood one clock earlier.
- R8: Requests latch whether or not the bit is enabled. The enable gates only `irq_o`.
- R9: Zero bits written to any set, clear or request address leave the affected state unchanged.
- R10: A request clear takes precedence over a request condition arising in the same cycle.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled. Address 8 returns the sensed vector, and addresses 9..15 return zero.
- R12: Pins pass through two synchronizer flops. A pin change sampled at clock edge k is latched as a request at edge k+2 and raises `irq_o` at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NPORT*16 | Raw pin levels of all ports, port p at bits 16p+15..16p |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
A pin change sampled at one edge reaches the request register two edges later and the interrupt output three edges later. The bench drives pins and bus strobes on the falling edge and counts the rising edges before each sample. A register write takes effect at the rising edge that samples it, so the enable changes there and `irq_o` follows one edge later. The level re-assertion after a clear is likewise visible as one cleared read followed by a set read. Read results are queued by the driver when the strobe is issued and compared by a monitor one rising edge later.

// File: rtl/pint_pkg.sv
package pint_pkg;
  localparam int VEC_W  = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = VEC_W / LANE_W;
  localparam int PORT_W = 16;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_EN_SET   = 4'd0,
    A_EN_CLR   = 4'd1,
    A_REQ      = 4'd2,
    A_STEER    = 4'd3,
    A_EDGE_SET = 4'd4,
    A_EDGE_CLR = 4'd5,
    A_INV_SET  = 4'd6,
    A_INV_CLR  = 4'd7,
    A_SENSE    = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/pint_sync.sv
module pint_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/pint_lane_mux.sv
module pint_lane_mux import pint_pkg::*; #(
  parameter int NPORT = 4
) (
  input  logic [NPORT*PORT_W-1:0] ports_i,
  input  logic [VEC_W-1:0]        steer_i,
  output logic [VEC_W-1:0]        vec_o
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    localparam int HALF_OFS = (b % 2) * LANE_W;
    logic [LANE_W-1:0] code;
    logic [LANE_W-1:0] lane;

    assign code = steer_i[b*LANE_W +: LANE_W];

    always_comb begin
      lane = '0;
      for (int p = 0; p < NPORT; p++) begin
        if (code == LANE_W'(p)) lane = ports_i[p*PORT_W + HALF_OFS +: LANE_W];
      end
    end

    assign vec_o[b*LANE_W +: LANE_W] = lane;
  end
endmodule

// File: rtl/pint_detect.sv
module pint_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] req_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sense_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic hit;
    logic req_q;

    assign hit = edge_i[i] ? (sense_i[i] & ~prev_q[i]) : sense_i[i];

    always_ff @(posedge clk) begin
      if (rst)           req_q <= 1'b0;
      else if (clr_i[i]) req_q <= 1'b0;
      else if (hit)      req_q <= 1'b1;
    end

    assign req_o[i] = req_q;
  end
endmodule

// File: rtl/pint_regs.sv
module pint_regs import pint_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [VEC_W-1:0]  wdata_i,
  output logic [VEC_W-1:0]  rdata_o,
  input  logic [VEC_W-1:0]  req_i,
  input  logic [VEC_W-1:0]  sense_i,
  output logic [VEC_W-1:0]  en_o,
  output logic [VEC_W-1:0]  edge_o,
  output logic [VEC_W-1:0]  inv_o,
  output logic [VEC_W-1:0]  steer_o,
  output logic [VEC_W-1:0]  clr_o
);
  logic [VEC_W-1:0] en_q, edge_q, inv_q, steer_q, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      edge_q  <= '0;
      inv_q   <= '0;
      steer_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_EN_SET:   en_q    <= en_q | wdata_i;
        A_EN_CLR:   en_q    <= en_q & ~wdata_i;
        A_EDGE_SET: edge_q  <= edge_q | wdata_i;
        A_EDGE_CLR: edge_q  <= edge_q & ~wdata_i;
        A_INV_SET:  inv_q   <= inv_q | wdata_i;
        A_INV_CLR:  inv_q   <= inv_q & ~wdata_i;
        A_STEER:    steer_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      case (addr_i)
        A_EN_SET, A_EN_CLR:     rdata_q <= en_q;
        A_EDGE_SET, A_EDGE_CLR: rdata_q <= edge_q;
        A_INV_SET, A_INV_CLR:   rdata_q <= inv_q;
        A_STEER:                rdata_q <= steer_q;
        A_REQ:                  rdata_q <= req_i;
        A_SENSE:                rdata_q <= sense_i;
        default:                rdata_q <= '0;
      endcase
    end
  end

  assign clr_o   = (wr_i && addr_i == A_REQ) ? wdata_i : '0;
  assign en_o    = en_q;
  assign edge_o  = edge_q;
  assign inv_o   = inv_q;
  assign steer_o = steer_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/pint_router.sv
module pint_router import pint_pkg::*; #(
  parameter int NPORT = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT*PORT_W-1:0] pins_i,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [VEC_W-1:0]        bus_wdata,
  output logic [VEC_W-1:0]        bus_rdata,
  output logic                    irq_o
);
  localparam int PIN_W = NPORT * PORT_W;

  logic [PIN_W-1:0] pins_s;
  logic [VEC_W-1:0] routed, sense, req_vec, en_vec, edge_vec, inv_vec, steer_vec, clr_vec;
  logic             irq_q;

  pint_sync #(.W(PIN_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pins_i),
    .q_o (pins_s)
  );

  pint_lane_mux #(.NPORT(NPORT)) u_mux (
    .ports_i (pins_s),
    .steer_i (steer_vec),
    .vec_o   (routed)
  );

  assign sense = routed ^ inv_vec;

  pint_detect #(.W(VEC_W)) u_det (
    .clk     (clk),
    .rst     (rst),
    .sense_i (sense),
    .edge_i  (edge_vec),
    .clr_i   (clr_vec),
    .req_o   (req_vec)
  );

  pint_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (bus_wr),
    .rd_i    (bus_rd),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .rdata_o (bus_rdata),
    .req_i   (req_vec),
    .sense_i (sense),
    .en_o    (en_vec),
    .edge_o  (edge_vec),
    .inv_o   (inv_vec),
    .steer_o (steer_vec),
    .clr_o   (clr_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(req_vec & en_vec);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pint_router_chk.sv
module pint_router_chk import pint_pkg::*; (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [VEC_W-1:0]  bus_wdata,
  input logic              irq_o,
  input logic [VEC_W-1:0]  req_vec,
  input logic [VEC_W-1:0]  en_vec
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && req_vec == '0 && en_vec == '0));

  p_irq_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == |($past(req_vec) & $past(en_vec))));

  p_en_set_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_EN_SET) |=> ((en_vec & $past(bus_wdata)) == $past(bus_wdata)));

  p_en_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_EN_CLR) |=> ((en_vec & $past(bus_wdata)) == '0));

  p_req_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_REQ) |=> ((req_vec & $past(bus_wdata)) == '0));

  p_en_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && (bus_addr == A_EN_SET || bus_addr == A_EN_CLR)) |=> $stable(en_vec));
endmodule

bind pint_router pint_router_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .req_vec   (req_vec),
  .en_vec    (en_vec)
);

// File: tb/pint_router_test.sv
module pint_router_test;
  import pint_pkg::*;
  localparam int NPORT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NPORT*16-1:0] pins = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        rd_seen;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  pint_router #(.NPORT(NPORT)) uut (
    .clk       (clk),
    .rst       (rst),
    .pins_i    (pins),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq)
  );

  always @(posedge clk) rd_seen <= rst ? 1'b0 : bus_rd;

  // monitor: pops the expected value for each read one edge after the strobe
  always @(negedge clk) begin
    exp_t e;
    if (rd_seen) begin
      n_cmp++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R11 read data %h with no expected entry", bus_rdata);
      end else begin
        e = sb.pop_front();
        if (bus_rdata !== e.exp) begin
          n_bad++;
          $display("FAIL %s read got %h expected %h", e.tag, bus_rdata, e.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb.push_back(e);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    n_cmp++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s irq got %b expected %b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state, R11 unmapped address
    chk_irq(1'b0, "R1");
    for (int a = 0; a < 9; a++) rd(4'(a), 32'h0, "R1");
    rd(4'hF, 32'h0, "R11");

    // R2 lane steering: lanes 0,1 <- port1, lane2 <- port3 low, lane3 <- port2 high
    wr(A_STEER, 32'h0203_0101);
    pins[19] = 1'b1;   // port1 pin3 -> vec bit3
    pins[44] = 1'b1;   // port2 pin12 -> lane3 bit4 -> vec bit28
    pins[50] = 1'b1;   // port3 pin2 -> lane2 bit2 -> vec bit18
    pins[0]  = 1'b1;   // port0 not routed
    idle(5);
    rd(A_SENSE, 32'h1004_0008, "R2");
    rd(A_STEER, 32'h0203_0101, "R2");
    rd(A_REQ, 32'h1004_0008, "R5");

    // R5/R10 level latch, clear and re-assert
    pins[44] = 1'b0; pins[50] = 1'b0; pins[0] = 1'b0;
    idle(5);
    rd(A_REQ, 32'h1004_0008, "R5");
    wr(A_REQ, 32'hFFFF_FFFF);
    rd(A_REQ, 32'h0, "R10");
    rd(A_REQ, 32'h8, "R5");
    pins[19] = 1'b0;
    idle(5);
    wr(A_REQ, 32'h8);
    idle(2);
    rd(A_REQ, 32'h0, "R6");

    // R3 invert flags
    wr(A_INV_SET, 32'h8);
    idle(5);
    rd(A_INV_SET, 32'h8, "R3");
    rd(A_INV_CLR, 32'h8, "R3");
    rd(A_SENSE, 32'h8, "R3");
    rd(A_REQ, 32'h8, "R3");
    wr(A_INV_CLR, 32'h8);
    wr(A_REQ, 32'hFFFF_FFFF);
    idle(2);
    rd(A_REQ, 32'h0, "R3");
    rd(A_INV_SET, 32'h0, "R3");

    // R4/R6 edge mode
    wr(A_EDGE_SET, 32'h8);
    rd(A_EDGE_CLR, 32'h8, "R4");
    pins[19] = 1'b1;
    idle(5);
    rd(A_REQ, 32'h8, "R4");
    wr(A_REQ, 32'h8);
    idle(3);
    rd(A_REQ, 32'h0, "R6");
    pins[19] = 1'b0;
    idle(5);
    rd(A_REQ, 32'h0, "R4");
    pins[19] = 1'b1;
    idle(5);
    rd(A_REQ, 32'h8, "R4");
    wr(A_REQ, 32'h8);
    wr(A_INV_SET, 32'h8);      // sensed bit falls: no request
    idle(3);
    rd(A_REQ, 32'h0, "R4");
    pins[19] = 1'b0;           // inverted pin falling = sensed rising
    idle(5);
    rd(A_REQ, 32'h8, "R3");

    // R8/R7 enable gating
    chk_irq(1'b0, "R8");
    wr(A_EN_SET, 32'h8);
    chk_irq(1'b0, "R7");
    idle(1);
    chk_irq(1'b1, "R7");
    rd(A_EN_SET, 32'h8, "R7");
    rd(A_EN_CLR, 32'h8, "R7");
    wr(A_EN_CLR, 32'h8);
    chk_irq(1'b1, "R7");
    idle(1);
    chk_irq(1'b0, "R7");

    // R9 zero writes have no effect
    wr(A_EN_SET, 32'h0);
    wr(A_EDGE_CLR, 32'h0);
    wr(A_INV_CLR, 32'h0);
    wr(A_REQ, 32'h0);
    rd(A_EN_SET, 32'h0, "R9");
    rd(A_EDGE_SET, 32'h8, "R9");
    rd(A_INV_SET, 32'h8, "R9");
    rd(A_REQ, 32'h8, "R9");
    rd(4'hC, 32'h0, "R11");

    // R12 pin-to-irq latency, level mode enabled
    wr(A_EDGE_CLR, 32'h8);
    wr(A_INV_CLR, 32'h8);
    wr(A_REQ, 32'hFFFF_FFFF);
    wr(A_EN_SET, 32'h8);
    idle(2);
    chk_irq(1'b0, "R12");
    pins[19] = 1'b1;
    idle(1); chk_irq(1'b0, "R12");
    idle(1); chk_irq(1'b0, "R12");
    idle(1); chk_irq(1'b0, "R12");
    idle(1); chk_irq(1'b1, "R12");

    // R10/R5 clear while level condition holds: irq dips for one cycle
    wr(A_REQ, 32'h8);
    chk_irq(1'b1, "R10");
    idle(1); chk_irq(1'b0, "R10");
    idle(1); chk_irq(1'b1, "R5");

    pins[19] = 1'b0;
    idle(4);
    wr(A_REQ, 32'hFFFF_FFFF);
    idle(2);
    chk_irq(1'b0, "R6");

    idle(3);
    if (sb.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 %0d reads never returned, expected 0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule